// File: doc/BRIEF.md
# Threshold Receive FIFO Controller

This block is the receive-side buffer between a serial frame receiver and a host bus. The receiver pushes bytes one at a time. The last byte of each frame carries an end marker. The block holds up to 32 bytes and hands them to the host in blocks. A block is normally as large as a programmable threshold. When the end of a frame falls inside the threshold window, the block is cut short so that it ends on that frame's final byte.

The host drains blocks in one of two ways. In interrupt mode, a one-cycle pulse announces each block: one pulse for a partial block and another for the end of a message. The host reads the block and then issues a release command. In DMA mode, a level request stays high while a block is outstanding and drops in the cycle that carries the block's last read. After the final block of a frame, a message-end pulse follows and the request stays locked until a release command. A running byte count for the current frame is available on two output fields, high and low. A sticky flag records any byte that was lost because the storage was full.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset both interrupt pulses, the DMA request, the frame count and the overflow flag are 0, and no block is presented while the storage is empty.
- R2: The threshold select picks the block size: 2'b00 selects 32 bytes, 2'b01 selects 16, 2'b10 selects 4 and 2'b11 selects 2. A full-size block is presented only once that many bytes are stored.
- R3: Bytes leave in the order they arrived. The read data output always shows the oldest stored byte, and each accepted read removes exactly that byte.
- R4: In interrupt mode, when a threshold-sized block is stored and it holds no end marker, `irqPartial` pulses high for exactly one cycle. This happens one clock after the edge at which the block became available.
- R5: In interrupt mode, when a stored end marker lies within the threshold window, `irqEnd` pulses instead. That block's length is the number of bytes up to and including the end marker.
- R6: Reads beyond the current block's length are ignored and leave the head byte unchanged. No further block is presented until `rmcCmd` releases the current one.
- R7: In DMA mode, `dmaReq` goes high the cycle after a block is presented. It stays high through every read of the block and is low during the cycle in which the block's last read is asserted.
- R8: In DMA mode, partial blocks raise no interrupt, and the last block of a frame is sized to the bytes that remain.
- R9: In DMA mode, `irqEnd` pulses in the cycle after the last byte of a frame is read. `dmaReq` then stays low until `rmcCmd`.
- R10: The 12-bit frame count, `{frameCntHi, frameCntLo}`, holds the number of bytes of the current frame handed over so far, including the block just presented. It restarts from zero with the first block of a new frame, and it equals the frame length when the message-end block is presented.
- R11: A byte that arrives while 32 bytes are stored and no read happens in that cycle is discarded, and it sets `overflow`, which stays set until reset.
- R12: A byte that arrives in the same cycle as an accepted read while the storage is full is stored without setting `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Receiver byte strobe |
| wrData | input | 8 | Received byte |
| wrEnd | input | 1 | Byte is the last of its frame |
| thrSel | input | 2 | Block size select (see R2) |
| dmaMode | input | 1 | 1 selects DMA draining, 0 selects interrupt draining |
| rdEn | input | 1 | Host read strobe, one byte per cycle |
| rmcCmd | input | 1 | Release command for the current block |
| rdData | output | 8 | Oldest stored byte |
| irqPartial | output | 1 | Partial-block interrupt pulse |
| irqEnd | output | 1 | Message-end interrupt pulse |
| dmaReq | output | 1 | Level DMA request |
| frameCntHi | output | 4 | Frame byte count, upper bits |
| frameCntLo | output | 8 | Frame byte count, lower bits |
| overflow | output | 1 | Sticky lost-byte flag |

## Verification
The receiver write and the host read can land on the same clock edge. This happens whenever a frame is still arriving while earlier blocks are being drained. The sweep provokes it constantly by running the writer and the host side by side over every threshold and every frame length from 1 to 32, in both modes, and it judges each byte against its arithmetic value and each block size against the expected split of the frame. A directed case places a write and a read in the same cycle while exactly 32 bytes are stored: the write must be kept with no overflow. A companion case checks that a write without a read at that point is dropped.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic pop;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_XFER,
    ST_LOCK
  } ctlState_t;

  // Block size chosen by the 2-bit select: 00 full depth, 01 half, 10 four, 11 two.
  function automatic int unsigned thrBytes(logic [1:0] sel, int unsigned depth);
    case (sel)
      2'b00:   return depth;
      2'b01:   return depth / 2;
      2'b10:   return 4;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEnd,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [OCC_W-1:0]  occ,
  output logic              eofFound,
  output logic [PTR_W-1:0]  eofDist,
  output logic              overflow
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  eofBits;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              isFull;
  logic              push;

  assign isFull = (occ == OCC_W'(DEPTH));
  assign push   = wrValid && (!isFull || strobe.pop);
  assign rdData = dataMem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) dataMem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      occ      <= '0;
      eofBits  <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) begin
        eofBits[wrPtr] <= wrEnd;
        wrPtr          <= wrPtr + 1'b1;
      end
      if (strobe.pop) rdPtr <= rdPtr + 1'b1;
      case ({push, strobe.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (wrValid && !push) overflow <= 1'b1;
    end
  end

  // Distance from the head to the first stored end marker.
  always_comb begin
    eofFound = 1'b0;
    eofDist  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!eofFound && (OCC_W'(i) < occ) && eofBits[rdPtr + PTR_W'(i)]) begin
        eofFound = 1'b1;
        eofDist  = PTR_W'(i);
      end
    end
  end

  assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> occ != '0);

  assert_occ_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_full_pop_push_R12: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && isFull && strobe.pop) |=> (occ == OCC_W'(DEPTH)) && !$rose(overflow));

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaMode,
  input  logic [1:0]       thrSel,
  input  logic             rdEn,
  input  logic             rmcCmd,
  input  logic [OCC_W-1:0] occ,
  input  logic             eofFound,
  input  logic [PTR_W-1:0] eofDist,
  output dpStrobe_t        strobe,
  output logic             irqPartial,
  output logic             irqEnd,
  output logic             dmaReq,
  output logic [CNT_W-1:0] frameCnt
);

  ctlState_t        st;
  logic [OCC_W-1:0] remCnt;
  logic             blkEnd;
  logic             newFrame;
  logic [OCC_W-1:0] thr;
  logic             endAvail;
  logic             avail;
  logic [OCC_W-1:0] nextLen;

  assign thr      = OCC_W'(thrBytes(thrSel, DEPTH));
  assign endAvail = eofFound && (OCC_W'(eofDist) < thr);
  assign avail    = endAvail || (occ >= thr);
  assign nextLen  = endAvail ? OCC_W'(eofDist) + 1'b1 : thr;

  assign strobe.pop = rdEn && (st == ST_HOLD || st == ST_XFER) && (remCnt != '0);
  assign dmaReq     = (st == ST_XFER) && !(rdEn && remCnt == OCC_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      remCnt     <= '0;
      blkEnd     <= 1'b0;
      newFrame   <= 1'b1;
      frameCnt   <= '0;
      irqPartial <= 1'b0;
      irqEnd     <= 1'b0;
    end else begin
      irqPartial <= 1'b0;
      irqEnd     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (avail) begin
            remCnt   <= nextLen;
            blkEnd   <= endAvail;
            newFrame <= endAvail;
            frameCnt <= (newFrame ? '0 : frameCnt) + CNT_W'(nextLen);
            if (dmaMode) begin
              st <= ST_XFER;
            end else begin
              st         <= ST_HOLD;
              irqPartial <= !endAvail;
              irqEnd     <= endAvail;
            end
          end
        end
        ST_HOLD: begin
          if (strobe.pop) remCnt <= remCnt - 1'b1;
          if (rmcCmd) st <= ST_IDLE;
        end
        ST_XFER: begin
          if (strobe.pop) begin
            remCnt <= remCnt - 1'b1;
            if (remCnt == OCC_W'(1)) begin
              if (blkEnd) begin
                st     <= ST_LOCK;
                irqEnd <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end
        default: begin
          if (rmcCmd) st <= ST_IDLE;
        end
      endcase
    end
  end

  assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqPartial, irqEnd}));

  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPartial |=> !irqPartial);

  assert_req_backed_R7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> occ >= remCnt);

  assert_end_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqEnd |-> frameCnt != '0);

endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int CNT_W  = 12,
  parameter int LO_W   = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  wrEnd,
  input  logic [1:0]            thrSel,
  input  logic                  dmaMode,
  input  logic                  rdEn,
  input  logic                  rmcCmd,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqPartial,
  output logic                  irqEnd,
  output logic                  dmaReq,
  output logic [CNT_W-LO_W-1:0] frameCntHi,
  output logic [LO_W-1:0]       frameCntLo,
  output logic                  overflow
);

  dpStrobe_t        strobe;
  logic [OCC_W-1:0] occ;
  logic             eofFound;
  logic [PTR_W-1:0] eofDist;
  logic [CNT_W-1:0] frameCnt;

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .wrData  (wrData),
    .wrEnd   (wrEnd),
    .strobe  (strobe),
    .rdData  (rdData),
    .occ     (occ),
    .eofFound(eofFound),
    .eofDist (eofDist),
    .overflow(overflow)
  );

  rxq_control #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .dmaMode   (dmaMode),
    .thrSel    (thrSel),
    .rdEn      (rdEn),
    .rmcCmd    (rmcCmd),
    .occ       (occ),
    .eofFound  (eofFound),
    .eofDist   (eofDist),
    .strobe    (strobe),
    .irqPartial(irqPartial),
    .irqEnd    (irqEnd),
    .dmaReq    (dmaReq),
    .frameCnt  (frameCnt)
  );

  assign frameCntHi = frameCnt[CNT_W-1:LO_W];
  assign frameCntLo = frameCnt[LO_W-1:0];

endmodule

// File: tb/test_rx_frame_fifo.sv
module test_rx_frame_fifo;

  logic       clk = 1'b0;
  logic       rstN, wrValid, wrEnd, dmaMode, rdEn, rmcCmd;
  logic [7:0] wrData;
  logic [1:0] thrSel;
  logic [7:0] rdData;
  logic       irqPartial, irqEnd, dmaReq, overflow;
  logic [3:0] frameCntHi;
  logic [7:0] frameCntLo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_frame_fifo i_rx_frame_fifo (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrEnd(wrEnd),
    .thrSel(thrSel), .dmaMode(dmaMode), .rdEn(rdEn), .rmcCmd(rmcCmd),
    .rdData(rdData), .irqPartial(irqPartial), .irqEnd(irqEnd), .dmaReq(dmaReq),
    .frameCntHi(frameCntHi), .frameCntLo(frameCntLo), .overflow(overflow)
  );

  function automatic logic [7:0] byteVal(int f, int i);
    return 8'(f * 37 + i * 11 + 5);
  endfunction

  function automatic int thrOf(int sel);
    case (sel)
      0: return 32;
      1: return 16;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int fcnt();
    return int'({frameCntHi, frameCntLo});
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrValid = 1'b0; wrEnd = 1'b0; wrData = '0;
    rdEn = 1'b0; rmcCmd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeFrame(int fno, int len, int gap, bit withEnd);
    for (int i = 0; i < len; i++) begin
      wrValid = 1'b1;
      wrData  = byteVal(fno, i);
      wrEnd   = withEnd && (i == len - 1);
      @(negedge clk);
      wrValid = 1'b0;
      wrEnd   = 1'b0;
      for (int g = 1; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic waitIrq(output bit ok);
    int w = 0;
    ok = 1'b1;
    while (!(irqPartial || irqEnd)) begin
      @(negedge clk);
      w++;
      if (w > 3000) begin ok = 1'b0; chk(0, "R4 irq timeout", 0, 1); return; end
    end
  endtask

  task automatic pulseRmc();
    rmcCmd = 1'b1;
    @(negedge clk);
    rmcCmd = 1'b0;
  endtask

  task automatic drainFrame(int fno, int len, int thr, bit dma);
    int rem = len;
    int idx = 0;
    int cum = 0;
    while (rem > 0) begin
      int sz = (rem > thr) ? thr : rem;
      bit isEnd = (rem <= thr);
      int w = 0;
      while (!(dma ? dmaReq : (irqPartial || irqEnd))) begin
        @(negedge clk);
        w++;
        if (w > 3000) begin chk(0, "R7 block timeout", 0, 1); return; end
      end
      cum += sz;
      if (dma) chk(!irqPartial && !irqEnd, "R8 no irq at dma block", int'(irqPartial), 0);
      else if (isEnd) chk(irqEnd && !irqPartial, "R5 end irq", int'(irqEnd), 1);
      else chk(irqPartial && !irqEnd, "R2/R4 partial irq", int'(irqPartial), 1);
      chk(fcnt() == cum, "R10 frame count", fcnt(), cum);
      for (int k = 0; k < sz; k++) begin
        chk(rdData == byteVal(fno, idx), "R3 data order", int'(rdData), int'(byteVal(fno, idx)));
        rdEn = 1'b1;
        if (dma) begin
          #1;
          chk(dmaReq == (k != sz - 1), "R7 request level", int'(dmaReq), int'(k != sz - 1));
        end
        @(negedge clk);
        rdEn = 1'b0;
        idx++;
      end
      if (dma) begin
        chk(irqEnd == isEnd, "R9 end irq after last read", int'(irqEnd), int'(isEnd));
        chk(!irqPartial, "R8 no partial irq", int'(irqPartial), 0);
        if (isEnd) begin
          repeat (2) begin
            chk(!dmaReq, "R9 locked until release", int'(dmaReq), 0);
            @(negedge clk);
          end
          pulseRmc();
        end
      end else begin
        pulseRmc();
      end
      rem -= sz;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    int fno = 0;
    thrSel = 2'b00;
    dmaMode = 1'b0;
    doReset();

    // R1 reset state and idle with empty storage
    chk(!irqPartial && !irqEnd, "R1 irq after reset", int'(irqPartial | irqEnd), 0);
    chk(!dmaReq && !overflow, "R1 req/ovf after reset", int'(dmaReq | overflow), 0);
    chk(fcnt() == 0, "R1 count after reset", fcnt(), 0);
    dmaMode = 1'b1;
    repeat (3) @(negedge clk);
    chk(!dmaReq, "R1 no block when empty", int'(dmaReq), 0);

    // R2 threshold 4: three bytes present nothing, the fourth presents a block
    doReset();
    dmaMode = 1'b0; thrSel = 2'b10;
    writeFrame(90, 3, 1, 1'b0);
    repeat (3) begin
      chk(!irqPartial && !irqEnd, "R2 below threshold", int'(irqPartial), 0);
      @(negedge clk);
    end
    wrValid = 1'b1; wrData = byteVal(90, 3); wrEnd = 1'b0;
    @(negedge clk);
    wrValid = 1'b0;
    @(negedge clk);
    chk(irqPartial, "R2 block at threshold", int'(irqPartial), 1);

    // R6 reads past the block and missing release
    doReset();
    dmaMode = 1'b0; thrSel = 2'b10;
    fork
      writeFrame(91, 6, 1, 1'b1);
      waitIrq(ok);
    join_any
    chk(irqPartial, "R4 partial first", int'(irqPartial), 1);
    for (int k = 0; k < 4; k++) begin
      rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    end
    wait fork;
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    chk(rdData == byteVal(91, 4), "R6 extra read ignored", int'(rdData), int'(byteVal(91, 4)));
    repeat (3) begin
      chk(!irqPartial && !irqEnd, "R6 no block before release", int'(irqEnd), 0);
      @(negedge clk);
    end
    pulseRmc();
    waitIrq(ok);
    chk(irqEnd, "R5 short end block", int'(irqEnd), 1);
    chk(fcnt() == 6, "R10 count at end", fcnt(), 6);
    repeat (2) begin rdEn = 1'b1; @(negedge clk); rdEn = 1'b0; end
    pulseRmc();

    // Sweep: both modes, all thresholds, every frame length up to the depth
    doReset();
    for (int m = 0; m < 2; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int len = 1; len <= 32; len++) begin
          fno++;
          dmaMode = m[0];
          thrSel = sel[1:0];
          fork
            writeFrame(fno, len, 1, 1'b1);
            drainFrame(fno, len, thrOf(sel), m[0]);
          join
        end
      end
    end
    chk(!overflow, "R11 no overflow in sweep", int'(overflow), 0);

    // R10 long frame, count crosses into the upper field
    dmaMode = 1'b1; thrSel = 2'b01;
    fork
      writeFrame(200, 300, 2, 1'b1);
      drainFrame(200, 300, 16, 1'b1);
    join
    chk(frameCntHi == 4'd1 && frameCntLo == 8'd44, "R10 split count", fcnt(), 300);

    // R12 write alongside read while full
    doReset();
    dmaMode = 1'b0; thrSel = 2'b00;
    fork
      writeFrame(92, 32, 1, 1'b0);
      waitIrq(ok);
    join
    rdEn = 1'b1; wrValid = 1'b1; wrData = 8'hA5; wrEnd = 1'b1;
    chk(rdData == byteVal(92, 0), "R3 head at full", int'(rdData), int'(byteVal(92, 0)));
    @(negedge clk);
    rdEn = 1'b0; wrValid = 1'b0; wrEnd = 1'b0;
    chk(!overflow, "R12 simultaneous write kept", int'(overflow), 0);
    for (int k = 1; k < 32; k++) begin
      chk(rdData == byteVal(92, k), "R3 data after full", int'(rdData), int'(byteVal(92, k)));
      rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    end
    pulseRmc();
    waitIrq(ok);
    chk(irqEnd && rdData == 8'hA5, "R12 kept byte delivered", int'(rdData), 165);
    chk(fcnt() == 33, "R10 count spans blocks", fcnt(), 33);
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    pulseRmc();

    // R11 write with no read while full
    doReset();
    dmaMode = 1'b0; thrSel = 2'b00;
    fork
      writeFrame(93, 33, 1, 1'b0);
      waitIrq(ok);
    join
    chk(overflow, "R11 overflow set", int'(overflow), 1);
    for (int k = 0; k < 32; k++) begin
      chk(rdData == byteVal(93, k), "R11 stored bytes intact", int'(rdData), int'(byteVal(93, k)));
      rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
    end
    pulseRmc();
    repeat (3) begin
      chk(!irqPartial && !irqEnd, "R11 dropped byte not stored", int'(irqEnd), 0);
      @(negedge clk);
    end
    chk(overflow, "R11 overflow sticky", int'(overflow), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule